// File: doc/BRIEF.md
# Input Capture Channel

This block is a single capture channel that hangs off a free-running counter owned elsewhere. An asynchronous pin is brought into the clock domain by a synchronizer chain. A state machine then qualifies each level change: a new level is accepted only after it has held for a programmable number of consecutive samples. Each accepted change becomes a one-cycle rising or falling pulse. Two polarity bits decide which of these pulses count. An event divider passes only every 1st, 2nd, 4th or 8th counted pulse, and each pulse it passes copies the counter into the channel register.

Every capture raises a sticky capture flag. A capture that arrives while that flag is still set also raises an overcapture flag. Either flag is gated by its own enable onto an interrupt line or a DMA request line. The channel register is shared with compare use: with capture mode off, software loads it directly; with capture mode on, it holds the captured value and direct loads are ignored.

The filter state machine has four states: `FLT_LOW`, `FLT_GOING_HIGH`, `FLT_HIGH` and `FLT_GOING_LOW`. A stable state moves to its pending state when the synchronized input differs from it. A pending state moves to the opposite stable state on acceptance, which emits the edge pulse. A pending state falls back to the stable state it came from if the input returns first. From a stable state, acceptance can also happen at once when the filter length is 0 or 1.

Top module: `icap_channel`

## Requirements
- R1: With filter length F, a pin change driven before clock edge k is captured at edge k+2+max(F,1), and the register then holds the counter value present at that edge.
- R2: With F of 2 or more, a pin pulse lasting fewer than F cycles produces no capture. A pulse lasting exactly F cycles is accepted.
- R3: Polarity code {pol_pri,pol_sec}=00 captures on rising edges only.
- R4: Polarity code 10 captures on falling edges only.
- R5: Polarity code 11 captures on both edges. Rising and falling pulses are never emitted in the same cycle.
- R6: Polarity code 01 behaves as rising-only.
- R7: Divider code psc_sel = 0, 1, 2, 3 captures on every 1st, 2nd, 4th or 8th selected edge respectively, counting from the first selected edge after the channel is activated.
- R8: The capture flag is set by each capture and stays set until clr_cap is pulsed. If a capture and clr_cap fall in the same cycle, the flag remains set.
- R9: A capture while the capture flag is already set raises over_flag. over_flag is cleared only by clr_over, and a capture in the same cycle wins.
- R10: irq_req is the capture flag gated by irq_en, and dma_req is the capture flag gated by dma_en.
- R11: With chan_en=0 no capture happens and the register is unchanged. The divider count returns to zero, so counting restarts after re-enabling.
- R12: With cap_mode=0, ccr_wr loads ccr_wdata into the register and no capture occurs. With cap_mode=1, ccr_wr has no effect.
- R13: After reset the register, both flags, irq_req and dma_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous capture pin |
| counter_in | input | CNT_W | Free-running timer count |
| cap_mode | input | 1 | 1 = capture use, 0 = compare use |
| chan_en | input | 1 | Channel enable |
| pol_pri | input | 1 | Primary polarity bit |
| pol_sec | input | 1 | Secondary polarity bit |
| psc_sel | input | PSC_W | Event divider code |
| filt_len | input | FILT_W | Filter length in samples (0 = none) |
| irq_en | input | 1 | Interrupt enable |
| dma_en | input | 1 | DMA request enable |
| clr_cap | input | 1 | Clear pulse for capture flag |
| clr_over | input | 1 | Clear pulse for overcapture flag |
| ccr_wr | input | 1 | Direct register load strobe |
| ccr_wdata | input | CNT_W | Direct load data |
| ccr_q | output | CNT_W | Channel register value |
| cap_flag | output | 1 | Sticky capture flag |
| over_flag | output | 1 | Sticky overcapture flag |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A capture and a software flag clear can land in the same cycle. The bench provokes this by counting the pipeline latency from the pin change (two synchronizer stages, filter acceptance, edge pulse register) and raising clr_cap exactly for the capture edge, with the flag already set by an earlier capture. The result is judged at the ports: the capture flag must still read 1, the overcapture flag must have risen, and the register must hold the counter value of that edge.

// File: rtl/icap_pkg.sv
package icap_pkg;

    typedef enum logic [1:0] {
        FLT_LOW        = 2'd0,
        FLT_GOING_HIGH = 2'd1,
        FLT_HIGH       = 2'd2,
        FLT_GOING_LOW  = 2'd3
    } flt_state_e;

    typedef struct packed {
        logic on_rise;
        logic on_fall;
    } edge_mask_t;

    // Primary bit clear selects rising only (secondary bit ignored);
    // primary set alone selects falling; both set selects either edge.
    function automatic edge_mask_t decode_polarity(input logic pri, input logic sec);
        edge_mask_t m;
        m.on_rise = !pri || sec;
        m.on_fall = pri;
        return m;
    endfunction

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [FILT_W-1:0] len,
    output logic              rise_p,
    output logic              fall_p
);
    flt_state_e        state_q, state_nx;
    logic [FILT_W-1:0] run_q, run_nx;
    logic [FILT_W:0]   run_inc;
    logic              accept;
    logic              rise_nx, fall_nx;

    assign run_inc = {1'b0, run_q} + 1'b1;
    assign accept  = (run_inc >= {1'b0, len});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_LOW;
            run_q   <= '0;
        end else begin
            state_q <= state_nx;
            run_q   <= run_nx;
        end
    end

    // next state and transition pulses
    always_comb begin
        state_nx = state_q;
        run_nx   = '0;
        rise_nx  = 1'b0;
        fall_nx  = 1'b0;
        unique case (state_q)
            FLT_LOW: begin
                if (din) begin
                    if (accept) begin
                        state_nx = FLT_HIGH;
                        rise_nx  = 1'b1;
                    end else begin
                        state_nx = FLT_GOING_HIGH;
                        run_nx   = run_inc[FILT_W-1:0];
                    end
                end
            end
            FLT_GOING_HIGH: begin
                if (!din) begin
                    state_nx = FLT_LOW;
                end else if (accept) begin
                    state_nx = FLT_HIGH;
                    rise_nx  = 1'b1;
                end else begin
                    run_nx = run_inc[FILT_W-1:0];
                end
            end
            FLT_HIGH: begin
                if (!din) begin
                    if (accept) begin
                        state_nx = FLT_LOW;
                        fall_nx  = 1'b1;
                    end else begin
                        state_nx = FLT_GOING_LOW;
                        run_nx   = run_inc[FILT_W-1:0];
                    end
                end
            end
            FLT_GOING_LOW: begin
                if (din) begin
                    state_nx = FLT_HIGH;
                end else if (accept) begin
                    state_nx = FLT_LOW;
                    fall_nx  = 1'b1;
                end else begin
                    run_nx = run_inc[FILT_W-1:0];
                end
            end
            default: state_nx = FLT_LOW;
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
        end else begin
            rise_p <= rise_nx;
            fall_p <= fall_nx;
        end
    end
endmodule

// File: rtl/icap_divider.sv
module icap_divider
    import icap_pkg::*;
#(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic             pol_pri,
    input  logic             pol_sec,
    input  logic [PSC_W-1:0] psc_sel,
    output logic             cap_evt
);
    localparam int CW = (1 << PSC_W) - 1;

    edge_mask_t     mask;
    logic           sel_evt;
    logic [CW:0]    span;
    logic [CW-1:0]  last;
    logic [CW-1:0]  cnt_q;

    assign mask    = decode_polarity(pol_pri, pol_sec);
    assign sel_evt = active && ((rise_p && mask.on_rise) || (fall_p && mask.on_fall));
    assign span    = {{CW{1'b0}}, 1'b1} << psc_sel;
    assign last    = CW'(span - 1'b1);
    assign cap_evt = sel_evt && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active) begin
            cnt_q <= '0;
        end else if (sel_evt) begin
            if (cnt_q >= last) cnt_q <= '0;
            else               cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/icap_channel.sv
module icap_channel
    import icap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FILT_W      = 4,
    parameter int PSC_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] counter_in,
    input  logic             cap_mode,
    input  logic             chan_en,
    input  logic             pol_pri,
    input  logic             pol_sec,
    input  logic [PSC_W-1:0] psc_sel,
    input  logic [FILT_W-1:0] filt_len,
    input  logic             irq_en,
    input  logic             dma_en,
    input  logic             clr_cap,
    input  logic             clr_over,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    output logic [CNT_W-1:0] ccr_q,
    output logic             cap_flag,
    output logic             over_flag,
    output logic             irq_req,
    output logic             dma_req
);
    logic pin_s;
    logic rise_p, fall_p;
    logic cap_evt;
    logic active;

    assign active = chan_en && cap_mode;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    icap_filter #(.FILT_W(FILT_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_s),
        .len    (filt_len),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    icap_divider #(.PSC_W(PSC_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (active),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .pol_pri (pol_pri),
        .pol_sec (pol_sec),
        .psc_sel (psc_sel),
        .cap_evt (cap_evt)
    );

    // shared channel register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ccr_q <= '0;
        else if (cap_evt)             ccr_q <= counter_in;
        else if (ccr_wr && !cap_mode) ccr_q <= ccr_wdata;
    end

    // sticky flags, set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_flag  <= 1'b0;
            over_flag <= 1'b0;
        end else begin
            if (cap_evt)      cap_flag <= 1'b1;
            else if (clr_cap) cap_flag <= 1'b0;

            if (cap_evt && cap_flag) over_flag <= 1'b1;
            else if (clr_over)       over_flag <= 1'b0;
        end
    end

    assign irq_req = cap_flag && irq_en;
    assign dma_req = cap_flag && dma_en;
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] counter_in,
    input logic             cap_mode,
    input logic             chan_en,
    input logic             ccr_wr,
    input logic             clr_cap,
    input logic             irq_en,
    input logic             dma_en,
    input logic [CNT_W-1:0] ccr_q,
    input logic             cap_flag,
    input logic             over_flag,
    input logic             irq_req,
    input logic             dma_req,
    input logic             cap_evt,
    input logic             rise_p,
    input logic             fall_p
);
    assert_capture_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> ccr_q == $past(counter_in));

    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_p, fall_p}));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag && !clr_cap |=> cap_flag);

    assert_overcapture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt && cap_flag |=> over_flag);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq_req);

    assert_dma_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |-> !dma_req);

    assert_no_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !cap_evt);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en && !ccr_wr |=> $stable(ccr_q));

    assert_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode && !cap_evt |=> $stable(ccr_q));
endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .counter_in (counter_in),
    .cap_mode   (cap_mode),
    .chan_en    (chan_en),
    .ccr_wr     (ccr_wr),
    .clr_cap    (clr_cap),
    .irq_en     (irq_en),
    .dma_en     (dma_en),
    .ccr_q      (ccr_q),
    .cap_flag   (cap_flag),
    .over_flag  (over_flag),
    .irq_req    (irq_req),
    .dma_req    (dma_req),
    .cap_evt    (cap_evt),
    .rise_p     (rise_p),
    .fall_p     (fall_p)
);

// File: tb/icap_channel_bench.sv
module icap_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic [15:0] counter_in = '0;
    logic        cap_mode = 1'b1, chan_en = 1'b0;
    logic        pol_pri = 1'b0, pol_sec = 1'b0;
    logic [1:0]  psc_sel = '0;
    logic [3:0]  filt_len = '0;
    logic        irq_en = 1'b0, dma_en = 1'b0;
    logic        clr_cap = 1'b0, clr_over = 1'b0;
    logic        ccr_wr = 1'b0;
    logic [15:0] ccr_wdata = '0;
    logic [15:0] ccr_q;
    logic        cap_flag, over_flag, irq_req, dma_req;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    icap_channel u_icap_channel (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .counter_in(counter_in),
        .cap_mode(cap_mode), .chan_en(chan_en), .pol_pri(pol_pri), .pol_sec(pol_sec),
        .psc_sel(psc_sel), .filt_len(filt_len), .irq_en(irq_en), .dma_en(dma_en),
        .clr_cap(clr_cap), .clr_over(clr_over), .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
        .ccr_q(ccr_q), .cap_flag(cap_flag), .over_flag(over_flag),
        .irq_req(irq_req), .dma_req(dma_req)
    );

    initial forever begin
        @(negedge clk);
        counter_in <= counter_in + 16'd1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic set_pin(input logic v, output logic [15:0] base);
        wait_neg(1);
        pin_in = v;
        base = counter_in;
    endtask

    task automatic clear_flags();
        wait_neg(1);
        clr_cap = 1'b1; clr_over = 1'b1;
        wait_neg(1);
        clr_cap = 1'b0; clr_over = 1'b0;
    endtask

    task automatic pulse_edge();
        logic [15:0] b;
        set_pin(1'b1, b);
        wait_neg(6);
        set_pin(1'b0, b);
        wait_neg(6);
    endtask

    initial begin
        logic [15:0] base, prev, exp_val;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        // R13 reset state
        check("R13 ccr", ccr_q, 0);
        check("R13 cap_flag", cap_flag, 0);
        check("R13 over_flag", over_flag, 0);
        check("R13 irq", irq_req, 0);
        check("R13 dma", dma_req, 0);

        chan_en = 1'b1;
        // sweep polarity code and filter length (R1, R3, R4, R5, R6)
        for (int pol = 0; pol < 4; pol++) begin
            for (int f = 0; f < 4; f++) begin
                string tag;
                logic rise_ok, fall_ok;
                int lat;
                tag = (pol == 0) ? "R1/R3" : (pol == 1) ? "R1/R6" : (pol == 2) ? "R1/R4" : "R1/R5";
                {pol_pri, pol_sec} = 2'(pol);
                rise_ok = (pol != 2);
                fall_ok = (pol >= 2);
                filt_len = 4'(f);
                psc_sel = 2'd0;
                lat = 2 + ((f > 1) ? f : 1);
                wait_neg(f + 8);
                clear_flags();
                prev = ccr_q;
                set_pin(1'b1, base);
                wait_neg(f + 8);
                exp_val = rise_ok ? base + 16'(lat) : prev;
                check({tag, " rise flag"}, cap_flag, rise_ok);
                check({tag, " rise value"}, ccr_q, exp_val);
                clear_flags();
                prev = ccr_q;
                set_pin(1'b0, base);
                wait_neg(f + 8);
                exp_val = fall_ok ? base + 16'(lat) : prev;
                check({tag, " fall flag"}, cap_flag, fall_ok);
                check({tag, " fall value"}, ccr_q, exp_val);
            end
        end

        // R7 divider sweep
        {pol_pri, pol_sec} = 2'b00;
        filt_len = 4'd0;
        for (int p = 0; p < 4; p++) begin
            psc_sel = 2'(p);
            chan_en = 1'b0;
            wait_neg(2);
            chan_en = 1'b1;
            clear_flags();
            for (int i = 0; i < 8; i++) begin
                logic [15:0] b;
                set_pin(1'b1, b);
                wait_neg(6);
                check("R7 divider", cap_flag, ((i + 1) % (1 << p)) == 0);
                clear_flags();
                set_pin(1'b0, b);
                wait_neg(6);
            end
        end
        psc_sel = 2'd0;

        // R2 glitch rejection
        for (int f = 2; f < 4; f++) begin
            for (int w = f - 1; w <= f; w++) begin
                filt_len = 4'(f);
                wait_neg(12);
                clear_flags();
                set_pin(1'b1, base);
                wait_neg(w - 1);
                set_pin(1'b0, base);
                wait_neg(f + 10);
                check("R2 glitch", cap_flag, w >= f);
            end
        end
        filt_len = 4'd0;
        wait_neg(8);

        // R8 / R9 flag behaviour
        clear_flags();
        pulse_edge();
        wait_neg(20);
        check("R8 sticky", cap_flag, 1);
        check("R9 no over yet", over_flag, 0);
        pulse_edge();
        check("R9 overcapture", over_flag, 1);
        wait_neg(1);
        clr_over = 1'b1;
        wait_neg(1);
        clr_over = 1'b0;
        check("R9 over cleared", over_flag, 0);
        check("R8 flag kept", cap_flag, 1);
        // capture and clear in the same cycle: capture at edge k+3
        set_pin(1'b1, base);
        wait_neg(3);
        clr_cap = 1'b1;
        wait_neg(1);
        clr_cap = 1'b0;
        check("R8 set wins", cap_flag, 1);
        check("R9 over on same cycle", over_flag, 1);
        check("R8 value", ccr_q, base + 16'd3);
        set_pin(1'b0, base);
        wait_neg(6);
        clear_flags();
        check("R8 cleared", cap_flag, 0);

        // R10 gating
        pulse_edge();
        for (int c = 0; c < 4; c++) begin
            irq_en = c[0];
            dma_en = c[1];
            wait_neg(1);
            check("R10 irq", irq_req, c[0]);
            check("R10 dma", dma_req, c[1]);
        end
        clear_flags();
        check("R10 irq off", irq_req, 0);
        check("R10 dma off", dma_req, 0);
        irq_en = 1'b0; dma_en = 1'b0;

        // R11 disabled channel
        chan_en = 1'b0;
        prev = ccr_q;
        pulse_edge();
        check("R11 no flag", cap_flag, 0);
        check("R11 value held", ccr_q, prev);
        chan_en = 1'b1;
        psc_sel = 2'd1;
        clear_flags();
        pulse_edge();
        check("R11 first of two", cap_flag, 0);
        chan_en = 1'b0;
        wait_neg(2);
        chan_en = 1'b1;
        pulse_edge();
        check("R11 count restarted", cap_flag, 0);
        pulse_edge();
        check("R11 second after restart", cap_flag, 1);
        psc_sel = 2'd0;
        clear_flags();

        // R12 shared register
        cap_mode = 1'b0;
        wait_neg(1);
        ccr_wr = 1'b1; ccr_wdata = 16'h1234;
        wait_neg(1);
        ccr_wr = 1'b0;
        check("R12 load", ccr_q, 16'h1234);
        pulse_edge();
        check("R12 no capture value", ccr_q, 16'h1234);
        check("R12 no capture flag", cap_flag, 0);
        cap_mode = 1'b1;
        wait_neg(1);
        ccr_wr = 1'b1; ccr_wdata = 16'h5555;
        wait_neg(1);
        ccr_wr = 1'b0;
        check("R12 write ignored", ccr_q, 16'h1234);
        set_pin(1'b1, base);
        wait_neg(6);
        check("R12 capture resumes", ccr_q, base + 16'd3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule